// File: doc/BRIEF.md
# Translation Buffer with Parallel Physically Tagged Cache Lookup

This block turns a 32-bit virtual address into a physical one and, in the same cycle, reads a small direct-mapped data cache. Because a page is 4 KB, the low 12 address bits never change under translation. The cache is indexed with those bits only, so the cache read and the associative search of the translation buffer on the 20-bit page number run side by side. The line tag read from the cache is then compared against the physical frame number produced by the translation buffer.

Each request gets exactly one result one cycle later. The result is one of four: a hit with the line data; a cache-miss request carrying the full physical address for the memory system; a translation-miss request carrying the page number for an external page-table walker; or a protection fault. Translation entries are loaded through a refill port. Cache lines are loaded through a line-fill port. A flush input drops every translation in a single cycle.

Top module: `vtlb_dcache`

## Requirements
- R1: After synchronous reset, no response or request output is active, and every translation entry is invalid, so the first lookup is a translation miss.
- R2: A request accepted on one clock edge produces a response on the following edge. The response raises exactly one of `rsp_hit`, `cmiss_valid`, `tmiss_valid` or `fault_valid`, and none of them is raised without a response.
- R3: If no valid entry matches `req_vaddr[31:12]`, the block raises `tmiss_valid` with `tmiss_vpn` equal to that page number.
- R4: The cache line is selected by `req_vaddr[11:2]`. A hit needs four things: the translation hits, the access is permitted, the line is valid, and the line tag equals the translated frame number. A read hit returns the line word on `rsp_rdata`.
- R5: If the translation hits and the access is permitted, but the line is invalid or its tag differs, the block raises `cmiss_valid` with `cmiss_paddr = {frame, req_vaddr[11:0]}` and `cmiss_write` equal to the request's write flag. Nothing is written into the cache.
- R6: The permission field has bit 0 set when reads are allowed and bit 1 set when writes are allowed. An access whose permission bit is clear raises `fault_valid`. A faulting write leaves the cache unchanged.
- R7: A write hit replaces the line word with `req_wdata`, and a later read returns the new value.
- R8: On a translation hit, `rsp_ref` and `rsp_dirty` report the entry's referenced and dirty bits as they stood before the access; both are 0 on a translation miss. A permitted access sets the referenced bit, and a permitted write sets the dirty bit. A fault changes neither bit. A refill loads the entry with both bits clear.
- R9: Refills fill entries in round-robin order starting at entry 0, and the buffer has 16 entries by default. The seventeenth refill therefore replaces the first page loaded.
- R10: A flush invalidates every entry in one cycle and leaves the refill order where it was. The next lookup of any page misses.
- R11: A line fill marks line `line_fill_paddr[11:2]` valid, with tag `line_fill_paddr[31:12]` and word `line_fill_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all translation entries |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address of the request |
| req_write | input | 1 | Request is a write |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Cache hit |
| rsp_rdata | output | 32 | Line word on a read hit |
| rsp_ref | output | 1 | Referenced bit of the matching entry before the access |
| rsp_dirty | output | 1 | Dirty bit of the matching entry before the access |
| cmiss_valid | output | 1 | Cache-miss request to memory |
| cmiss_paddr | output | 32 | Physical address of the cache miss |
| cmiss_write | output | 1 | The missing access was a write |
| tmiss_valid | output | 1 | Translation-miss request to the walker |
| tmiss_vpn | output | 20 | Page number that missed |
| fault_valid | output | 1 | Protection fault |
| tlb_fill_valid | input | 1 | Load one translation entry |
| tlb_fill_vpn | input | 20 | Page number of the new entry |
| tlb_fill_pfn | input | 20 | Frame number of the new entry |
| tlb_fill_perm | input | 2 | Permission field: bit 0 read, bit 1 write |
| line_fill_valid | input | 1 | Load one cache line |
| line_fill_paddr | input | 32 | Physical address of the line |
| line_fill_data | input | 32 | Word written into the line |

## Verification
The checks assume a few things about the inputs. The refill port never loads a page number that is already present, so at most one entry matches. A line fill never lands in the same cycle as a request to that line. While reset is held, no request or flush is driven. The bench respects all three. It gives its sixteen refills distinct page numbers and its replacement refill a new one. It issues fills, flushes and requests in separate cycles. It holds every input low during reset. Under these conditions, a request that follows a flush with no refill in between must report a translation miss. Every cache-miss and translation-miss request must echo the page offset and page number of the request from the cycle before.

// File: rtl/vtlbc_pkg.sv
package vtlbc_pkg;

    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PFN_W  = 20;
    localparam int PA_W   = PFN_W + OFF_W;
    localparam int BSEL_W = 2;
    localparam int LIDX_W = OFF_W - BSEL_W;
    localparam int DATA_W = 32;

    typedef logic [VPN_W-1:0]  vpn_t;
    typedef logic [PFN_W-1:0]  pfn_t;
    typedef logic [LIDX_W-1:0] lidx_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [PA_W-1:0]   paddr_t;

    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
    } perm_t;

    typedef struct packed {
        logic  valid;
        vpn_t  vpn;
        pfn_t  pfn;
        perm_t perm;
        logic  refd;
        logic  dirty;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        RES_HIT   = 2'd0,
        RES_CMISS = 2'd1,
        RES_TMISS = 2'd2,
        RES_FAULT = 2'd3
    } res_e;

    typedef struct packed {
        logic   valid;
        res_e   res;
        word_t  data;
        logic   refd;
        logic   dirty;
        paddr_t paddr;
        vpn_t   vpn;
        logic   write;
    } rsp_t;

    function automatic logic perm_allows(input perm_t p, input logic wr);
        return wr ? p.wr_ok : p.rd_ok;
    endfunction

    function automatic res_e classify(input logic tlb_hit, input logic allowed,
                                      input logic tag_eq);
        if (!tlb_hit)      return RES_TMISS;
        else if (!allowed) return RES_FAULT;
        else if (tag_eq)   return RES_HIT;
        else               return RES_CMISS;
    endfunction

endpackage

// File: rtl/vtlbc_tlb.sv
module vtlbc_tlb
    import vtlbc_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     flush,
    input  vpn_t     look_vpn,
    input  logic     upd_en,
    input  logic     upd_dirty,
    input  logic     fill_valid,
    input  vpn_t     fill_vpn,
    input  pfn_t     fill_pfn,
    input  perm_t    fill_perm,
    output logic     look_hit,
    output tlb_ent_t look_ent
);

    localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PW-1:0] LAST = PW'(ENTRIES - 1);

    logic [PW-1:0]      ptr_q;
    logic [ENTRIES-1:0] match;
    tlb_ent_t           sel [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (fill_valid && !flush) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + PW'(1);
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        tlb_ent_t e_q;
        logic     take;

        assign take = fill_valid && (ptr_q == PW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                e_q <= '0;
            end else if (flush) begin
                e_q.valid <= 1'b0;
            end else if (take) begin
                e_q.valid <= 1'b1;
                e_q.vpn   <= fill_vpn;
                e_q.pfn   <= fill_pfn;
                e_q.perm  <= fill_perm;
                e_q.refd  <= 1'b0;
                e_q.dirty <= 1'b0;
            end else if (match[g] && upd_en) begin
                e_q.refd <= 1'b1;
                if (upd_dirty) begin
                    e_q.dirty <= 1'b1;
                end
            end
        end

        assign match[g] = e_q.valid && (e_q.vpn == look_vpn);
        assign sel[g]   = match[g] ? e_q : '0;
    end

    always_comb begin
        look_ent = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            look_ent = look_ent | sel[i];
        end
    end

    assign look_hit = |match;

endmodule

// File: rtl/vtlbc_lines.sv
module vtlbc_lines
    import vtlbc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lidx_t rd_idx,
    output logic  rd_valid,
    output pfn_t  rd_tag,
    output word_t rd_data,
    input  logic  fill_en,
    input  lidx_t fill_idx,
    input  pfn_t  fill_tag,
    input  word_t fill_data,
    input  logic  wr_en,
    input  lidx_t wr_idx,
    input  word_t wr_data
);

    localparam int LINES = 1 << LIDX_W;

    logic [LINES-1:0] vld_q;
    pfn_t             tag_m [LINES];
    word_t            dat_m [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (fill_en) begin
            vld_q[fill_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_m[fill_idx] <= fill_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            dat_m[fill_idx] <= fill_data;
        end else if (wr_en) begin
            dat_m[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = vld_q[rd_idx];
    assign rd_tag   = tag_m[rd_idx];
    assign rd_data  = dat_m[rd_idx];

endmodule

// File: rtl/vtlb_dcache.sv
module vtlb_dcache
    import vtlbc_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_ref,
    output logic              rsp_dirty,
    output logic              cmiss_valid,
    output logic [PA_W-1:0]   cmiss_paddr,
    output logic              cmiss_write,
    output logic              tmiss_valid,
    output logic [VPN_W-1:0]  tmiss_vpn,
    output logic              fault_valid,
    input  logic              tlb_fill_valid,
    input  logic [VPN_W-1:0]  tlb_fill_vpn,
    input  logic [PFN_W-1:0]  tlb_fill_pfn,
    input  logic [1:0]        tlb_fill_perm,
    input  logic              line_fill_valid,
    input  logic [PA_W-1:0]   line_fill_paddr,
    input  logic [DATA_W-1:0] line_fill_data
);

    vpn_t     req_vpn;
    lidx_t    req_idx;
    logic     tlb_hit;
    tlb_ent_t ent;
    logic     line_valid;
    pfn_t     line_tag;
    word_t    line_data;
    logic     allowed;
    logic     tag_eq;
    res_e     res;
    logic     upd_en;
    logic     wr_hit;
    rsp_t     rsp_d;
    rsp_t     rsp_q;

    assign req_vpn = req_vaddr[VA_W-1:OFF_W];
    assign req_idx = req_vaddr[OFF_W-1:BSEL_W];

    vtlbc_tlb #(.ENTRIES(ENTRIES)) u_tlb (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .look_vpn   (req_vpn),
        .upd_en     (upd_en),
        .upd_dirty  (req_write),
        .fill_valid (tlb_fill_valid),
        .fill_vpn   (tlb_fill_vpn),
        .fill_pfn   (tlb_fill_pfn),
        .fill_perm  (perm_t'(tlb_fill_perm)),
        .look_hit   (tlb_hit),
        .look_ent   (ent)
    );

    vtlbc_lines u_lines (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (req_idx),
        .rd_valid  (line_valid),
        .rd_tag    (line_tag),
        .rd_data   (line_data),
        .fill_en   (line_fill_valid),
        .fill_idx  (line_fill_paddr[OFF_W-1:BSEL_W]),
        .fill_tag  (line_fill_paddr[PA_W-1:OFF_W]),
        .fill_data (line_fill_data),
        .wr_en     (wr_hit),
        .wr_idx    (req_idx),
        .wr_data   (req_wdata)
    );

    always_comb begin
        allowed = perm_allows(ent.perm, req_write);
        tag_eq  = line_valid && (line_tag == ent.pfn);
        res     = classify(tlb_hit, allowed, tag_eq);
        upd_en  = req_valid && tlb_hit && allowed;
        wr_hit  = req_valid && req_write && (res == RES_HIT);

        rsp_d.valid = req_valid;
        rsp_d.res   = res;
        rsp_d.data  = line_data;
        rsp_d.refd  = tlb_hit && ent.refd;
        rsp_d.dirty = tlb_hit && ent.dirty;
        rsp_d.paddr = {ent.pfn, req_vaddr[OFF_W-1:0]};
        rsp_d.vpn   = req_vpn;
        rsp_d.write = req_write;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_hit     = rsp_q.valid && (rsp_q.res == RES_HIT);
    assign rsp_rdata   = rsp_q.data;
    assign rsp_ref     = rsp_q.refd;
    assign rsp_dirty   = rsp_q.dirty;
    assign cmiss_valid = rsp_q.valid && (rsp_q.res == RES_CMISS);
    assign cmiss_paddr = rsp_q.paddr;
    assign cmiss_write = rsp_q.write;
    assign tmiss_valid = rsp_q.valid && (rsp_q.res == RES_TMISS);
    assign tmiss_vpn   = rsp_q.vpn;
    assign fault_valid = rsp_q.valid && (rsp_q.res == RES_FAULT);

endmodule

// File: rtl/vtlbc_chk.sv
module vtlbc_chk
    import vtlbc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             req_write,
    input logic             tlb_fill_valid,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             cmiss_valid,
    input logic [PA_W-1:0]  cmiss_paddr,
    input logic             cmiss_write,
    input logic             tmiss_valid,
    input logic [VPN_W-1:0] tmiss_vpn,
    input logic             fault_valid
);

    p_one_result_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $onehot({rsp_hit, cmiss_valid, tmiss_valid, fault_valid}));

    p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(rsp_hit || cmiss_valid || tmiss_valid || fault_valid));

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_valid)) |-> rsp_valid);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid));

    p_tmiss_page_r3: assert property (@(posedge clk) disable iff (rst)
        tmiss_valid |-> (tmiss_vpn == $past(req_vaddr[VA_W-1:OFF_W])));

    p_cmiss_addr_r5: assert property (@(posedge clk) disable iff (rst)
        cmiss_valid |-> ((cmiss_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]))
                         && (cmiss_write == $past(req_write))));

    p_flush_miss_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(flush) && req_valid && !tlb_fill_valid) |=> tmiss_valid);

endmodule

bind vtlb_dcache vtlbc_chk u_chk (.*);

// File: tb/vtlb_dcache_test.sv
module vtlb_dcache_test;

    localparam int CLK_PERIOD = 10;
    localparam int N     = 16;
    localparam int LINES = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_hit, rsp_ref, rsp_dirty;
    logic [31:0] rsp_rdata;
    logic        cmiss_valid, cmiss_write, tmiss_valid, fault_valid;
    logic [31:0] cmiss_paddr;
    logic [19:0] tmiss_vpn;
    logic        tlb_fill_valid = 1'b0;
    logic [19:0] tlb_fill_vpn = '0;
    logic [19:0] tlb_fill_pfn = '0;
    logic [1:0]  tlb_fill_perm = '0;
    logic        line_fill_valid = 1'b0;
    logic [31:0] line_fill_paddr = '0;
    logic [31:0] line_fill_data = '0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench model of the requirements
    bit          m_v     [N];
    logic [19:0] m_vpn   [N];
    logic [19:0] m_pfn   [N];
    logic [1:0]  m_perm  [N];
    bit          m_ref   [N];
    bit          m_dirty [N];
    int          m_ptr = 0;
    bit          c_v    [LINES];
    logic [19:0] c_tag  [LINES];
    logic [31:0] c_data [LINES];

    vtlb_dcache uut (
        .clk(clk), .rst(rst), .flush(flush),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_rdata(rsp_rdata), .rsp_ref(rsp_ref), .rsp_dirty(rsp_dirty),
        .cmiss_valid(cmiss_valid), .cmiss_paddr(cmiss_paddr), .cmiss_write(cmiss_write),
        .tmiss_valid(tmiss_valid), .tmiss_vpn(tmiss_vpn), .fault_valid(fault_valid),
        .tlb_fill_valid(tlb_fill_valid), .tlb_fill_vpn(tlb_fill_vpn),
        .tlb_fill_pfn(tlb_fill_pfn), .tlb_fill_perm(tlb_fill_perm),
        .line_fill_valid(line_fill_valid), .line_fill_paddr(line_fill_paddr),
        .line_fill_data(line_fill_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic tlb_load(input logic [19:0] vpn, input logic [19:0] pfn,
                            input logic [1:0] perm);
        @(negedge clk);
        tlb_fill_valid = 1'b1;
        tlb_fill_vpn   = vpn;
        tlb_fill_pfn   = pfn;
        tlb_fill_perm  = perm;
        @(negedge clk);
        tlb_fill_valid = 1'b0;
        m_v[m_ptr]     = 1'b1;
        m_vpn[m_ptr]   = vpn;
        m_pfn[m_ptr]   = pfn;
        m_perm[m_ptr]  = perm;
        m_ref[m_ptr]   = 1'b0;
        m_dirty[m_ptr] = 1'b0;
        m_ptr = (m_ptr + 1) % N;
    endtask

    // R11: line fill places tag and word at paddr[11:2]
    task automatic line_load(input logic [31:0] pa, input logic [31:0] d);
        @(negedge clk);
        line_fill_valid = 1'b1;
        line_fill_paddr = pa;
        line_fill_data  = d;
        @(negedge clk);
        line_fill_valid = 1'b0;
        c_v[pa[11:2]]    = 1'b1;
        c_tag[pa[11:2]]  = pa[31:12];
        c_data[pa[11:2]] = d;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int e = 0; e < N; e++) m_v[e] = 1'b0;
    endtask

    task automatic access(input logic [31:0] va, input logic we, input logic [31:0] wd,
                          input string lbl);
        int k;
        int eo;
        logic [9:0] ix;
        logic [19:0] vpn;
        logic [3:0] ev;
        string rq;
        k   = -1;
        vpn = va[31:12];
        ix  = va[11:2];
        for (int e = 0; e < N; e++) if (m_v[e] && m_vpn[e] == vpn) k = e;
        if (k < 0) eo = 2;
        else if (!(we ? m_perm[k][1] : m_perm[k][0])) eo = 3;
        else if (c_v[ix] && c_tag[ix] == m_pfn[k]) eo = 0;
        else eo = 1;
        ev = 4'b1000 >> eo;
        rq = (eo == 0) ? "R4" : (eo == 1) ? "R5" : (eo == 2) ? "R3" : "R6";
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = we;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R2", {lbl, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk({rsp_hit, cmiss_valid, tmiss_valid, fault_valid} == ev, rq, {lbl, " result"},
            64'({rsp_hit, cmiss_valid, tmiss_valid, fault_valid}), 64'(ev));
        if (eo == 2)
            chk(tmiss_vpn == vpn, "R3", {lbl, " tmiss_vpn"}, 64'(tmiss_vpn), 64'(vpn));
        if (eo == 1) begin
            chk(cmiss_paddr == {m_pfn[k], va[11:0]}, "R5", {lbl, " cmiss_paddr"},
                64'(cmiss_paddr), 64'({m_pfn[k], va[11:0]}));
            chk(cmiss_write == we, "R5", {lbl, " cmiss_write"}, 64'(cmiss_write), 64'(we));
        end
        if (eo == 0 && !we)
            chk(rsp_rdata == c_data[ix], "R4", {lbl, " rdata"}, 64'(rsp_rdata),
                64'(c_data[ix]));
        if (k >= 0) begin
            chk(rsp_ref == m_ref[k], "R8", {lbl, " ref"}, 64'(rsp_ref), 64'(m_ref[k]));
            chk(rsp_dirty == m_dirty[k], "R8", {lbl, " dirty"}, 64'(rsp_dirty),
                64'(m_dirty[k]));
        end else begin
            chk(!rsp_ref && !rsp_dirty, "R8", {lbl, " bits on miss"},
                64'({rsp_ref, rsp_dirty}), 64'd0);
        end
        if (k >= 0 && eo != 3) begin
            m_ref[k] = 1'b1;
            if (we) m_dirty[k] = 1'b1;
        end
        if (eo == 0 && we) c_data[ix] = wd;
    endtask

    function automatic logic [19:0] vpn_of(input int i);
        return 20'h00400 + 20'(i * 3);
    endfunction

    function automatic logic [19:0] pfn_of(input int i);
        return 20'h80000 ^ 20'(i * 20'h00111);
    endfunction

    function automatic logic [11:0] off_of(input int i);
        return 12'((i * 5 + 3) << 2);
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int e = 0; e < N; e++) m_v[e] = 1'b0;
        for (int l = 0; l < LINES; l++) c_v[l] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk(!rsp_valid && !rsp_hit && !cmiss_valid && !tmiss_valid && !fault_valid,
            "R1", "outputs after reset",
            64'({rsp_valid, rsp_hit, cmiss_valid, tmiss_valid, fault_valid}), 64'd0);
        access(32'h0040_1234, 1'b0, '0, "R1 empty buffer");

        // load all entries; perm = i mod 4 (bit0 read, bit1 write)
        for (int i = 0; i < N; i++) tlb_load(vpn_of(i), pfn_of(i), 2'(i % 4));

        // empty cache: permitted accesses miss, ref goes 0 then 1
        for (int r = 0; r < 2; r++)
            for (int i = 0; i < N; i++)
                access({vpn_of(i), off_of(i)}, 1'b0, '0, "R8 cold sweep");

        // fill a line for every frame, then read, write, read back
        for (int i = 0; i < N; i++)
            line_load({pfn_of(i), off_of(i)}, 32'hC0DE_0000 + 32'(i));
        for (int i = 0; i < N; i++)
            access({vpn_of(i), off_of(i)}, 1'b0, '0, "R11 read after fill");
        for (int i = 0; i < N; i++)
            access({vpn_of(i), off_of(i)}, 1'b1, 32'h5A00_0000 + 32'(i * 7), "R6 write");
        for (int i = 0; i < N; i++)
            access({vpn_of(i), off_of(i)}, 1'b0, '0, "R7 read back");

        // tag mismatch: page i+1 at the line holding page i's frame
        for (int i = 0; i < N - 1; i++)
            access({vpn_of(i + 1), off_of(i)}, 1'b0, '0, "R5 tag mismatch");
        access({vpn_of(3), off_of(1)}, 1'b1, 32'hDEAD_BEEF, "R5 write miss");

        // unmapped pages
        for (int i = 0; i < 4; i++)
            access({20'hF0000 + 20'(i), 12'h010}, 1'b0, '0, "R3 unmapped");

        // R9: seventeenth refill replaces the first page
        tlb_load(20'hABCDE, pfn_of(3), 2'b11);
        access({vpn_of(0), off_of(0)}, 1'b0, '0, "R9 evicted");
        access({20'hABCDE, off_of(3)}, 1'b0, '0, "R9 new entry");
        access({vpn_of(1), off_of(1)}, 1'b0, '0, "R9 survivor");

        // R10: flush drops every page
        do_flush();
        for (int i = 1; i < N; i++)
            access({vpn_of(i), off_of(i)}, 1'b0, '0, "R10 after flush");
        access({20'hABCDE, off_of(3)}, 1'b0, '0, "R10 after flush");
        tlb_load(vpn_of(7), pfn_of(7), 2'b11);
        access({vpn_of(7), off_of(7)}, 1'b0, '0, "R10 refill after flush");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule